// File: doc/BRIEF.md
# UART FIFO Ready-Pin Controller

This block follows the fill level of one serial channel's transmit and receive queues, each 16 bytes deep, and from those levels drives two active-low ready pins for an external transfer engine. It also drives two line-status bits for the transmit side: one says that space for another byte is free, and the other says that the transmitter has gone completely quiet. The block holds no data bytes. It counts the push and pop strobes that the datapath raises, so that each level always matches the real queue.

The pins follow one of three rules. With the queues disabled, each side acts as a single holding register. With the queues enabled and block transfer off, a pin reports whether one character can move. With block transfer on, the receive pin waits for a programmable trigger level or a character timeout, then stays asserted until the queue has drained completely. In that mode the transmit pin stays asserted while any slot is free.

Top module: `uart_rdy_ctl`

## Requirements
- R1: After reset, rxrdy_n is 1, txrdy_n is 0, both overrun flags are 0, thr_space is 1 and tx_idle equals the inverse of tx_busy.
- R2: With fifo_en=0, the receive side holds at most one byte. rxrdy_n is 0 while a byte is held and 1 while none is held.
- R3: With fifo_en=0, the transmit side holds at most one byte. txrdy_n is 0 while it is empty and 1 while it holds a byte.
- R4: With fifo_en=1 and block_mode=0, rxrdy_n is 0 while the receive level is at least 1 and 1 when the level is 0.
- R5: With fifo_en=1 and block_mode=0, txrdy_n is 0 when the transmit level is 0 and 1 when it is at least 1.
- R6: With fifo_en=1 and block_mode=1, rxrdy_n falls when the receive level reaches the threshold chosen by rx_trig_sel (code 0=1, 1=4, 2=8, 3=14 bytes), or when rx_timeout pulses while the level is not 0. It then stays 0 until the level is 0. It does not fall while the level is below the threshold and no timeout occurs.
- R7: With fifo_en=1 and block_mode=1, txrdy_n is 0 while the transmit level is below 16 and 1 when the level is 16.
- R8: thr_space is 1 while the transmit level is below the capacity (1 with fifo_en=0, 16 otherwise). tx_idle is 1 when the transmit level is 0 and tx_busy is 0. Both follow the level with no register of their own.
- R9: A push to a full side is dropped and sets that side's sticky overrun flag. A pop from an empty side leaves the level at 0.
- R10: On a clock edge where fifo_en is 0 and was 1 at the edge before, both levels and both overrun flags clear. While fifo_en is 0, block_mode has no effect.
- R11: The ready pins are registered. They reflect a level one clock edge after the edge that changed it.
- R12: A push and a pop in the same cycle on a full side are both accepted, the level stays at the capacity and no overrun is flagged. On an empty side only the push takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_en | input | 1 | Queue enable; 0 selects single holding register behaviour |
| block_mode | input | 1 | Block transfer mode for the ready pins |
| rx_trig_sel | input | 2 | Receive trigger level select |
| rx_push | input | 1 | Receive byte written into the queue |
| rx_pop | input | 1 | Receive byte read out of the queue |
| rx_timeout | input | 1 | Receive character-timeout pulse |
| tx_push | input | 1 | Transmit byte written into the queue |
| tx_pop | input | 1 | Transmit byte moved to the shifter |
| tx_busy | input | 1 | Transmit shifter active |
| rxrdy_n | output | 1 | Receive ready, active low |
| txrdy_n | output | 1 | Transmit ready, active low |
| thr_space | output | 1 | Line status: transmit slot free |
| tx_idle | output | 1 | Line status: transmitter fully empty |
| rx_overrun | output | 1 | Sticky receive push-to-full flag |
| tx_overrun | output | 1 | Sticky transmit push-to-full flag |

## Verification
A strobe sampled at edge k changes the level at k. The status bits and overrun flags therefore change at edge k, and the ready pins change at edge k+1. The bench keeps a shadow model that, for each edge, first derives the next pin values from the levels held before that edge and only then applies the strobes. Inputs change one nanosecond after an edge, and every output is compared one nanosecond after the next edge against that model. The directed checks name the exact cycle on each side of the pin latency, of the block-mode trigger and hold, and of the flush.

// File: rtl/frc_pkg.sv
// Package: types and helpers shared by the ready-pin controller.
// Assumes receive thresholds scale with the queue depth.
package frc_pkg;

    typedef enum logic [1:0] {
        MODE_SINGLE = 2'd0,
        MODE_FIFO   = 2'd1,
        MODE_BLOCK  = 2'd2
    } frc_mode_e;

    // Receive trigger threshold in bytes for a select code.
    function automatic int trig_level(input logic [1:0] sel, input int depth);
        case (sel)
            2'd0:    return 1;
            2'd1:    return depth / 4;
            2'd2:    return depth / 2;
            default: return depth - 2;
        endcase
    endfunction

endpackage

// File: rtl/frc_level_ctr.sv
// Level counter for one queue: tracks occupancy from push/pop strobes.
// Assumes: capacity is 1 in single mode and DEPTH otherwise; flush wins
// over strobes; a push to a full queue is accepted only with a valid pop.
module frc_level_ctr #(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          single,
    input  logic          push,
    input  logic          pop,
    output logic [CW-1:0] count,
    output logic          overrun
);

    logic [CW-1:0] cap;
    logic          pop_ok;
    logic          push_ok;

    // Capacity and acceptance of this cycle's strobes.
    always_comb begin
        cap     = single ? CW'(1) : CW'(DEPTH);
        pop_ok  = pop && (count != '0);
        push_ok = push && ((count < cap) || pop_ok);
    end

    // Level and sticky overrun update.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            count   <= '0;
            overrun <= 1'b0;
        end else begin
            case ({push_ok, pop_ok})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
            if (push && !push_ok) overrun <= 1'b1;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH)); // R9

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !flush && count == cap) |=> (count == $past(count)) && overrun); // R9

    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !flush && count == '0) |=> (count == '0)); // R9

    AST_FLUSH_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0) && !overrun); // R10

endmodule

// File: rtl/frc_rx_pin.sv
// Receive-ready pin: registered, active low, with block-mode hysteresis.
// Assumes count is the registered receive level; the pin reflects it one
// edge later.
module frc_rx_pin
    import frc_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  frc_mode_e     mode,
    input  logic [1:0]    trig_sel,
    input  logic          timeout,
    input  logic [CW-1:0] count,
    output logic          rxrdy_n
);

    logic [CW-1:0] trig;

    // Threshold for the selected code.
    always_comb trig = CW'(trig_level(trig_sel, DEPTH));

    // Pin update: level rule, or set-at-trigger / clear-at-empty in block mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rxrdy_n <= 1'b1;
        end else if (mode == MODE_BLOCK) begin
            if (count == '0)
                rxrdy_n <= 1'b1;
            else if ((count >= trig) || timeout)
                rxrdy_n <= 1'b0;
        end else begin
            rxrdy_n <= (count == '0);
        end
    end

    AST_RX_EMPTY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |=> rxrdy_n); // R4

    AST_RX_BLK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_BLOCK && count != '0 && !rxrdy_n) |=> !rxrdy_n); // R6

endmodule

// File: rtl/frc_tx_pin.sv
// Transmit-ready pin (registered, active low) and the two transmit line
// status bits (combinational from the registered level).
// Assumes count is the registered transmit level.
module frc_tx_pin
    import frc_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  frc_mode_e     mode,
    input  logic          busy,
    input  logic [CW-1:0] count,
    output logic          txrdy_n,
    output logic          thr_space,
    output logic          tx_idle
);

    // Status bits from the current level.
    always_comb begin
        thr_space = (mode == MODE_SINGLE) ? (count == '0) : (count < CW'(DEPTH));
        tx_idle   = (count == '0) && !busy;
    end

    // Pin update: free-slot rule in block mode, empty rule otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            txrdy_n <= 1'b0;
        else if (mode == MODE_BLOCK)
            txrdy_n <= (count == CW'(DEPTH));
        else
            txrdy_n <= (count != '0);
    end

    AST_TX_EMPTY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |=> !txrdy_n); // R5

    AST_TX_FULL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_BLOCK && count == CW'(DEPTH)) |=> txrdy_n); // R7

endmodule

// File: rtl/uart_rdy_ctl.sv
// Top: ready-pin controller for one channel's receive and transmit queues.
// Assumes strobes are single-cycle per byte and come from the datapath
// that owns the storage; reset is synchronous and active low.
module uart_rdy_ctl
    import frc_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fifo_en,
    input  logic       block_mode,
    input  logic [1:0] rx_trig_sel,
    input  logic       rx_push,
    input  logic       rx_pop,
    input  logic       rx_timeout,
    input  logic       tx_push,
    input  logic       tx_pop,
    input  logic       tx_busy,
    output logic       rxrdy_n,
    output logic       txrdy_n,
    output logic       thr_space,
    output logic       tx_idle,
    output logic       rx_overrun,
    output logic       tx_overrun
);

    localparam int CW = $clog2(DEPTH + 1);

    frc_mode_e     mode;
    logic          en_q;
    logic          flush;
    logic          single;
    logic [CW-1:0] rx_count;
    logic [CW-1:0] tx_count;

    // Mode decode; block_mode counts only while the queues are enabled.
    always_comb begin
        if (!fifo_en)        mode = MODE_SINGLE;
        else if (block_mode) mode = MODE_BLOCK;
        else                 mode = MODE_FIFO;
        single = !fifo_en;
        flush  = en_q && !fifo_en;
    end

    // Previous enable, to find the disabling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= fifo_en;
    end

    frc_level_ctr #(.DEPTH(DEPTH), .CW(CW)) u_rx_lvl (
        .clk(clk), .rst_n(rst_n), .flush(flush), .single(single),
        .push(rx_push), .pop(rx_pop), .count(rx_count), .overrun(rx_overrun)
    );

    frc_level_ctr #(.DEPTH(DEPTH), .CW(CW)) u_tx_lvl (
        .clk(clk), .rst_n(rst_n), .flush(flush), .single(single),
        .push(tx_push), .pop(tx_pop), .count(tx_count), .overrun(tx_overrun)
    );

    frc_rx_pin #(.DEPTH(DEPTH), .CW(CW)) u_rx_pin (
        .clk(clk), .rst_n(rst_n), .mode(mode), .trig_sel(rx_trig_sel),
        .timeout(rx_timeout), .count(rx_count), .rxrdy_n(rxrdy_n)
    );

    frc_tx_pin #(.DEPTH(DEPTH), .CW(CW)) u_tx_pin (
        .clk(clk), .rst_n(rst_n), .mode(mode), .busy(tx_busy),
        .count(tx_count), .txrdy_n(txrdy_n), .thr_space(thr_space),
        .tx_idle(tx_idle)
    );

    AST_SINGLE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && !flush) |-> (rx_count <= CW'(1)) && (tx_count <= CW'(1))); // R2

endmodule

// File: tb/uart_rdy_ctl_bench.sv
module uart_rdy_ctl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;

    logic clk = 1'b0;
    logic rst_n, fifo_en, block_mode, rx_push, rx_pop, rx_timeout;
    logic tx_push, tx_pop, tx_busy;
    logic [1:0] rx_trig_sel;
    logic rxrdy_n, txrdy_n, thr_space, tx_idle, rx_overrun, tx_overrun;

    int checks = 0;
    int errors = 0;

    // Shadow model state.
    int m_rx = 0, m_tx = 0;
    bit m_rov = 0, m_tov = 0, m_enq = 0;
    logic m_rxn = 1'b1, m_txn = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_rdy_ctl #(.DEPTH(DEPTH)) u_uart_rdy_ctl (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .block_mode(block_mode),
        .rx_trig_sel(rx_trig_sel), .rx_push(rx_push), .rx_pop(rx_pop),
        .rx_timeout(rx_timeout), .tx_push(tx_push), .tx_pop(tx_pop),
        .tx_busy(tx_busy), .rxrdy_n(rxrdy_n), .txrdy_n(txrdy_n),
        .thr_space(thr_space), .tx_idle(tx_idle), .rx_overrun(rx_overrun),
        .tx_overrun(tx_overrun)
    );

    function automatic int trig_of(input logic [1:0] sel);
        case (sel)
            2'd0: return 1;
            2'd1: return 4;
            2'd2: return 8;
            default: return 14;
        endcase
    endfunction

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic upd(ref int c, ref bit ov, input logic pu, input logic po, input int cap);
        bit pop_ok, push_ok;
        pop_ok  = po && (c != 0);
        push_ok = pu && ((c < cap) || pop_ok);
        if (pu && !push_ok) ov = 1'b1;
        c = c + int'(push_ok) - int'(pop_ok);
    endtask

    // One clock: predict, advance, compare 1 ns after the edge.
    task automatic step();
        bit single, blk, flush;
        int cap;
        logic nrx, ntx;
        string rtag, ttag;
        single = !fifo_en;
        blk    = fifo_en && block_mode;
        flush  = m_enq && !fifo_en;
        cap    = single ? 1 : DEPTH;
        if (blk)
            nrx = (m_rx == 0) ? 1'b1 :
                  ((m_rx >= trig_of(rx_trig_sel) || rx_timeout) ? 1'b0 : m_rxn);
        else
            nrx = (m_rx == 0);
        ntx = blk ? (m_tx == DEPTH) : (m_tx != 0);
        if (!rst_n) begin
            m_rx = 0; m_tx = 0; m_rov = 0; m_tov = 0; m_enq = 0;
            m_rxn = 1'b1; m_txn = 1'b0;
        end else begin
            if (flush) begin
                m_rx = 0; m_tx = 0; m_rov = 0; m_tov = 0;
            end else begin
                upd(m_rx, m_rov, rx_push, rx_pop, cap);
                upd(m_tx, m_tov, tx_push, tx_pop, cap);
            end
            m_enq = fifo_en; m_rxn = nrx; m_txn = ntx;
        end
        @(posedge clk);
        #1;
        rtag = single ? "R2" : (blk ? "R6" : "R4");
        ttag = single ? "R3" : (blk ? "R7" : "R5");
        chk({rtag, " rxrdy_n"}, rxrdy_n, m_rxn);
        chk({ttag, " txrdy_n"}, txrdy_n, m_txn);
        chk("R8 thr_space", thr_space, m_tx < cap);
        chk("R8 tx_idle", tx_idle, (m_tx == 0) && !tx_busy);
        chk("R9 rx_overrun", rx_overrun, m_rov);
        chk("R9 tx_overrun", tx_overrun, m_tov);
    endtask

    task automatic quiet();
        rx_push = 0; rx_pop = 0; rx_timeout = 0; tx_push = 0; tx_pop = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: got hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        rst_n = 0; fifo_en = 0; block_mode = 0; rx_trig_sel = 0; tx_busy = 0;
        quiet();
        repeat (3) step();
        chk("R1 rxrdy_n", rxrdy_n, 1'b1);
        chk("R1 txrdy_n", txrdy_n, 1'b0);
        chk("R1 thr_space", thr_space, 1'b1);
        chk("R1 tx_idle", tx_idle, 1'b1);
        chk("R1 rx_overrun", rx_overrun, 1'b0);
        rst_n = 1;
        step();

        // Single holding register behaviour.
        rx_push = 1; step(); rx_push = 0; step();
        chk("R2 byte held", rxrdy_n, 1'b0);
        rx_push = 1; step(); rx_push = 0;
        chk("R9 second byte dropped", rx_overrun, 1'b1);
        tx_push = 1; step(); tx_push = 0;
        chk("R8 holding full", thr_space, 1'b0);
        step();
        chk("R3 holding full", txrdy_n, 1'b1);
        tx_pop = 1; step(); tx_pop = 0;
        chk("R8 idle", tx_idle, 1'b1);
        step();
        chk("R3 holding empty", txrdy_n, 1'b0);
        rx_pop = 1; step(); rx_pop = 0; step();
        chk("R2 no data", rxrdy_n, 1'b1);

        // Queue mode, pin latency.
        fifo_en = 1; step();
        rx_push = 1; step(); rx_push = 0;
        chk("R11 pin not yet", rxrdy_n, 1'b1);
        step();
        chk("R11 pin one edge later", rxrdy_n, 1'b0);
        tx_push = 1; repeat (3) step(); tx_push = 0; step();
        chk("R5 bytes queued", txrdy_n, 1'b1);

        // Block mode, trigger 8.
        block_mode = 1; rx_trig_sel = 2'd2;
        rx_pop = 1; step(); rx_pop = 0; step();
        chk("R6 drained", rxrdy_n, 1'b1);
        rx_push = 1; repeat (7) step(); rx_push = 0; step();
        chk("R6 below trigger", rxrdy_n, 1'b1);
        rx_push = 1; step(); rx_push = 0; step();
        chk("R6 at trigger", rxrdy_n, 1'b0);
        rx_pop = 1; repeat (7) step(); rx_pop = 0; step();
        chk("R6 hold above empty", rxrdy_n, 1'b0);
        rx_pop = 1; step(); rx_pop = 0; step();
        chk("R6 release at empty", rxrdy_n, 1'b1);
        rx_trig_sel = 2'd3;
        rx_push = 1; repeat (2) step(); rx_push = 0; step();
        chk("R6 below 14", rxrdy_n, 1'b1);
        rx_timeout = 1; step(); rx_timeout = 0;
        chk("R6 timeout", rxrdy_n, 1'b0);
        step();
        chk("R6 timeout hold", rxrdy_n, 1'b0);

        // Block mode transmit: level 3 -> 16.
        tx_push = 1; repeat (13) step(); tx_push = 0; step();
        chk("R7 full", txrdy_n, 1'b1);
        chk("R8 no space", thr_space, 1'b0);
        tx_push = 1; step(); tx_push = 0;
        chk("R9 tx push to full", tx_overrun, 1'b1);
        tx_pop = 1; step(); tx_pop = 0; step();
        chk("R7 slot free", txrdy_n, 1'b0);

        // Disable flushes; block_mode ignored.
        fifo_en = 0; step(); step();
        chk("R10 rx flushed", rxrdy_n, 1'b1);
        chk("R10 tx flushed", txrdy_n, 1'b0);
        chk("R10 overrun cleared", tx_overrun, 1'b0);
        chk("R10 idle", tx_idle, 1'b1);
        tx_push = 1; step(); tx_push = 0; step();
        chk("R10 block_mode ignored", txrdy_n, 1'b1);
        tx_pop = 1; step(); tx_pop = 0; step();

        // Simultaneous strobes on full and empty.
        fifo_en = 1; block_mode = 0;
        rx_pop = 1; step(); rx_pop = 0;
        rx_push = 1; step(); rx_push = 0; step();
        chk("R9 pop on empty kept level 0", rxrdy_n, 1'b0);
        rx_pop = 1; step(); rx_pop = 0; step();
        chk("R9 single byte removed", rxrdy_n, 1'b1);
        rx_push = 1; repeat (16) step();
        rx_pop = 1; step(); rx_pop = 0;
        chk("R12 push+pop on full", rx_overrun, 1'b0);
        step(); rx_push = 0;
        chk("R9 rx push to full", rx_overrun, 1'b1);
        rx_pop = 1; repeat (15) step(); rx_pop = 0; step();
        chk("R12 level kept at 16", rxrdy_n, 1'b0);
        rx_pop = 1; step(); rx_pop = 0; step();
        chk("R12 drained", rxrdy_n, 1'b1);

        // Constrained random.
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 199) == 0) fifo_en = ~fifo_en;
            if ($urandom_range(0, 49) == 0) block_mode = ~block_mode;
            if ($urandom_range(0, 29) == 0) rx_trig_sel = 2'($urandom_range(0, 3));
            rx_push    = ($urandom_range(0, 99) < 45);
            rx_pop     = ($urandom_range(0, 99) < 35);
            tx_push    = ($urandom_range(0, 99) < 40);
            tx_pop     = ($urandom_range(0, 99) < 40);
            rx_timeout = ($urandom_range(0, 99) < 3);
            tx_busy    = ($urandom_range(0, 99) < 30);
            step();
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule